// File: doc/BRIEF.md
# Serial Bus Hold Controller

This block sits between the synchronised serial pins of a flash-style slave and its instruction decoder. It implements the pause function of the hold pin. While chip select is low, a low level on the hold pin freezes the decoder. The decoder's bit counters and partial shift contents stay intact, and the serial data output is released to high impedance. The transfer then resumes at the exact bit where it stopped.

Everything runs on one fast system clock. The chip select, serial clock and hold pins first pass through a synchroniser chain of configurable depth. The block then finds edges on the synchronised serial clock and hold lines. It gives the decoder two single-cycle strobes, one on each serial clock edge, and it gates both strobes while the pause is active. A separate output enable tells the pad when the slave may drive its data line.

Hold changes state only while the serial clock is low. A hold edge that arrives while the serial clock is high is stored, and it takes effect at the next falling edge of the serial clock.

Top module: `spi_hold_ctrl`

## Requirements
- R1: A pause can start only while chip select (`cs_ni`) is low. A falling edge on `hold_ni` while `cs_ni` is high never sets `held_o`.
- R2: With `cs_ni` low, a change on `hold_ni` while `sck_i` is low takes effect at once. A falling edge sets `held_o`, a rising edge clears it. Either change shows within SYNC_STAGES+2 clock cycles.
- R3: With `cs_ni` low, a change on `hold_ni` while `sck_i` is high is deferred. It is applied at the next falling edge of `sck_i`, and it sets `held_o` to the inverse of the `hold_ni` level at that moment.
- R4: Leaving the pause follows the same rule. A rise of `hold_ni` while `sck_i` is low clears `held_o` directly. A rise while `sck_i` is high clears it only at the next falling edge of `sck_i`.
- R5: While `held_o` is 1, `so_oe_o`, `rise_en_o` and `fall_en_o` are all 0, whatever `sck_i` does.
- R6: If `cs_ni` goes high during a pause, `held_o` stays 1 as long as `hold_ni` stays low. It clears as soon as `hold_ni` is high while `cs_ni` is high.
- R7: A rising edge on `cs_ni` drops any deferred request. A later falling edge of `sck_i` with no new `hold_ni` edge leaves `held_o` unchanged.
- R8: Outside a pause and with `cs_ni` low, each rising edge of `sck_i` gives exactly one `rise_en_o` pulse, and each falling edge gives exactly one `fall_en_o` pulse. The edge on which a deferred entry takes effect still counts. The edge on which a deferred exit takes effect does not, so each serial clock cycle is counted exactly once across a pause.
- R9: After reset, `held_o`, `so_oe_o`, `rise_en_o` and `fall_en_o` are 0. Asserting `rst_ni` during a pause clears `held_o`.
- R10: `so_oe_o` is 1 exactly when the synchronised `cs_ni` is low and `held_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| hold_ni | input | 1 | Hold pin, active low |
| held_o | output | 1 | Pause active |
| so_oe_o | output | 1 | Output enable for the serial data pad |
| rise_en_o | output | 1 | Decoder strobe on a serial clock rising edge |
| fall_en_o | output | 1 | Decoder strobe on a serial clock falling edge |

## Verification
A wrong pause state shows within one system cycle. The data pad enable drops or rises at the wrong time, and the decoder strobes leak out or go missing. Either fault appears by the next serial clock edge. A lost or stale deferred request shows only at the following falling edge of the serial clock, where `held_o` fails to change or changes when it should not. Miscounted strobes across a pause show as a shortfall or surplus in the number of rising and falling strobes against the serial clock cycles the bench drives.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic hold_n;
  } pins_t;

  localparam int unsigned PIN_W = $bits(pins_t);
  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned    STAGES  = 2,
  parameter int unsigned    WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
  parameter int unsigned      WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] prev_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else prev_q <= d_i;
  end

  assign prev_o = prev_q;
  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  input  logic hold_edge_i,
  input  logic sck_fall_i,
  output logic held_o,
  output logic pend_o
);
  logic held_q, held_d;
  logic pend_q, pend_d;

  always_comb begin
    held_d = held_q;
    pend_d = pend_q;
    if (cs_n_i) begin
      // deselected: drop deferred work, release only when hold pin is high
      pend_d = 1'b0;
      if (held_q && hold_n_i) held_d = 1'b0;
    end else if (hold_edge_i && !sck_i) begin
      held_d = !hold_n_i;
      pend_d = 1'b0;
    end else if (hold_edge_i) begin
      pend_d = 1'b1;
    end else if (sck_fall_i && pend_q) begin
      held_d = !hold_n_i;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      held_q <= held_d;
      pend_q <= pend_d;
    end
  end

  assign held_o = held_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  output logic held_o,
  output logic so_oe_o,
  output logic rise_en_o,
  output logic fall_en_o
);
  localparam int unsigned EDGE_W = 2;
  localparam logic [EDGE_W-1:0] EDGE_RST = {PINS_IDLE.sck, PINS_IDLE.hold_n};

  pins_t pins_raw, pins_s;
  logic  cs_s, sck_s, hold_s;
  logic [EDGE_W-1:0] edge_prev, edge_rise, edge_fall;
  logic  sck_rise, sck_fall, hold_edge;
  logic  held, pend;

  assign pins_raw = '{cs_n: cs_ni, sck: sck_i, hold_n: hold_ni};

  spi_hold_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (PIN_W),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign cs_s   = pins_s.cs_n;
  assign sck_s  = pins_s.sck;
  assign hold_s = pins_s.hold_n;

  spi_hold_edge #(
    .WIDTH  (EDGE_W),
    .RST_VAL(EDGE_RST)
  ) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_s, hold_s}),
    .prev_o(edge_prev),
    .rise_o(edge_rise),
    .fall_o(edge_fall)
  );

  assign sck_rise  = edge_rise[1];
  assign sck_fall  = edge_fall[1];
  assign hold_edge = edge_rise[0] | edge_fall[0];

  spi_hold_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_s),
    .sck_i      (sck_s),
    .hold_n_i   (hold_s),
    .hold_edge_i(hold_edge),
    .sck_fall_i (sck_fall),
    .held_o     (held),
    .pend_o     (pend)
  );

  // strobes gate on the registered state: the entry edge counts, the exit edge does not
  assign held_o    = held;
  assign so_oe_o   = !cs_s && !held;
  assign rise_en_o = sck_rise && !cs_s && !held;
  assign fall_en_o = sck_fall && !cs_s && !held;
endmodule

// File: rtl/spi_hold_ctrl_chk.sv
module spi_hold_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic sck_s,
  input logic hold_s,
  input logic pend,
  input logic held_o,
  input logic so_oe_o,
  input logic rise_en_o,
  input logic fall_en_o
);
  p_entry_cs_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_o) |-> !$past(cs_s));

  p_entry_sck_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_o) |-> !$past(sck_s));

  p_exit_sck_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(held_o) && !$past(cs_s)) |-> !$past(sck_s));

  p_oe_off_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_o |-> (!so_oe_o && !rise_en_o && !fall_en_o));

  p_release_hold_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_o) |-> $past(hold_s));

  p_cs_drops_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_s) |-> !pend);

  p_one_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_en_o, fall_en_o}));
endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_s     (cs_s),
  .sck_s    (sck_s),
  .hold_s   (hold_s),
  .pend     (pend),
  .held_o   (held_o),
  .so_oe_o  (so_oe_o),
  .rise_en_o(rise_en_o),
  .fall_en_o(fall_en_o)
);

// File: tb/spi_hold_ctrl_tb.sv
module spi_hold_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1;
  logic held, so_oe, rise_en, fall_en;
  int total = 0, bad = 0;
  int n_rise = 0, n_fall = 0;

  always #4 clk = ~clk;

  spi_hold_ctrl #(.SYNC_STAGES(2)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cs_ni    (cs_n),
    .sck_i    (sck),
    .hold_ni  (hold_n),
    .held_o   (held),
    .so_oe_o  (so_oe),
    .rise_en_o(rise_en),
    .fall_en_o(fall_en)
  );

  always @(negedge clk) begin
    if (rise_en) n_rise++;
    if (fall_en) n_fall++;
  end

  // {cs_n, sck, hold_n, exp_held, exp_oe}, applied in order
  localparam logic [4:0] VEC [25] = '{
    5'b10100, 5'b00101, 5'b00010, 5'b01010, 5'b00010,
    5'b00101, 5'b01101, 5'b01001, 5'b00010, 5'b01010,
    5'b01110, 5'b00101, 5'b01101, 5'b01001, 5'b11000,
    5'b01001, 5'b00001, 5'b00101, 5'b00010, 5'b10010,
    5'b00010, 5'b10010, 5'b10100, 5'b10000, 5'b00001
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic s, input logic h);
    cs_n = c; sck = s; hold_n = h;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_sck(input int n);
    for (int k = 0; k < n; k++) begin
      drive(cs_n, 1'b1, hold_n);
      drive(cs_n, 1'b0, hold_n);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0, f0;
    repeat (3) @(negedge clk);
    check({held, so_oe, rise_en, fall_en} == 4'b0, "R9 reset", {held, so_oe, rise_en, fall_en}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R3 R4 R6 R7 R10 table
    for (int i = 0; i < 25; i++) begin
      drive(VEC[i][4], VEC[i][3], VEC[i][2]);
      check(held == VEC[i][1], $sformatf("R1-table step %0d held (R2 R3 R4 R6 R7)", i), held, VEC[i][1]);
      check(so_oe == VEC[i][0], $sformatf("R10 step %0d so_oe", i), so_oe, VEC[i][0]);
    end

    // R8: strobes outside a pause
    drive(1'b0, 1'b0, 1'b1);
    r0 = n_rise; f0 = n_fall;
    pulse_sck(3);
    check(n_rise - r0 == 3, "R8 rise strobes", n_rise - r0, 3);
    check(n_fall - f0 == 3, "R8 fall strobes", n_fall - f0, 3);

    // R5: sck ignored during a pause
    drive(1'b0, 1'b0, 1'b0);
    check(held == 1'b1, "R2 coincident entry", held, 1);
    pulse_sck(4);
    check(n_rise - r0 == 3, "R5 rise gated", n_rise - r0, 3);
    check(n_fall - f0 == 3, "R5 fall gated", n_fall - f0, 3);
    check(so_oe == 1'b0, "R5 so_oe off", so_oe, 0);
    drive(1'b0, 1'b0, 1'b1);
    pulse_sck(2);
    check(n_rise - r0 == 5, "R8 resume rise", n_rise - r0, 5);

    // R8: deferred entry edge counted, deferred exit edge not
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    check(held == 1'b1, "R3 deferred entry", held, 1);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1);
    check(held == 1'b1, "R4 exit waits for sck low", held, 1);
    drive(1'b0, 1'b0, 1'b1);
    check(held == 1'b0, "R4 deferred exit", held, 0);
    pulse_sck(1);
    check(n_rise - r0 == 7, "R8 rise across pause", n_rise - r0, 7);
    check(n_fall - f0 == 7, "R8 fall across pause", n_fall - f0, 7);

    // R9: reset during a pause
    drive(1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check(held == 1'b0, "R9 reset clears pause", held, 0);
    hold_n = 1'b1;
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(held == 1'b0 && so_oe == 1'b0, "R9 after reset idle", {held, so_oe}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule